// File: doc/BRIEF.md
# Wilkinson Rundown Conversion Sequencer

This block is the digital controller beside an in-pixel time-to-digital converter of the Wilkinson kind. When a hit strobe arrives it closes the charge switch so that a current source starts filling a small integration capacitor. It opens that switch at the next rising clock edge, so the stored voltage measures the interval from the hit to that edge. It then closes a transfer switch that shares the charge onto a capacitor four times as large. Last, it closes a rundown switch that discharges the large capacitor linearly toward the reference level, and it counts clock cycles until the analog comparator reports that the reference has been reached. The cycle count is the fine time result.

The three switches are never closed together, and one cycle with every switch open lies between any two switch phases. A missing comparator response is caught by a saturating counter that ends the rundown and raises an overflow flag. Hits that arrive while a conversion is running cannot restart it. They are tallied in a saturating dead-time counter. The result leaves as a single-cycle valid strobe with the count and the overflow flag. This port has no ready input and so no back-pressure: the sink must take the result in the strobe cycle. The count and the flag hold their values until the next conversion completes.

Top module: `rundown_seq`

## Requirements
- R1: After reset all three switch outputs are low, busy and valid are low, and the fine count, overflow flag and dead-time count are zero.
- R2: A hit sampled high while idle drives the charge switch high in that same cycle, combinationally. The charge switch is low from the next rising edge on, and busy is high from that edge.
- R3: After the charge cycle, one cycle passes with all switches open. The transfer switch is then high for exactly `xfer_len` cycles, and a value of 0 acts as 1.
- R4: After the transfer phase, one cycle passes with all switches open. The rundown switch is then high until the conversion ends.
- R5: At most one of the three switch outputs is high in any cycle.
- R6: The fine count equals the number of cycles the rundown switch was high, including the cycle in which the comparator flag was sampled high. Valid is high for exactly one cycle: the first cycle after the rundown switch falls.
- R7: If the comparator never responds, the rundown ends after 255 cycles with a fine count of 255 and the overflow flag at 1. A normal conversion leaves overflow at 0.
- R8: Every cycle in which busy and the hit input are both high adds one to the dead-time count, and such a hit has no effect on the running conversion. This includes the final rundown cycle.
- R9: When a conversion ends, the block is idle in the valid cycle. A hit in that cycle starts a new conversion.
- R10: The fine count and the overflow flag keep their values until the next conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Hit leading-edge strobe |
| cmp_i | input | 1 | Comparator flag: the rundown has reached the reference level |
| xfer_len_i | input | 4 | Transfer-phase length in cycles (0 acts as 1) |
| sw_charge_o | output | 1 | Charge switch enable |
| sw_xfer_o | output | 1 | Transfer switch enable |
| sw_ramp_o | output | 1 | Rundown switch enable |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| fine_o | output | 8 | Fine count (held) |
| ovf_o | output | 1 | Rundown counter saturated without a comparator response |
| dead_cnt_o | output | 16 | Number of hits rejected while busy |

## Verification
The end of a conversion and a rejected hit can fall in the same cycle, when the comparator flag is high and a hit also arrives in the last rundown cycle. The bench holds the hit high through every busy cycle, including that last one. It then expects that cycle's hit to be counted as dead and the result to still be correct. It keeps the hit high into the valid cycle that follows and expects a fresh conversion to start there, with the charge switch high alongside the valid strobe.

// File: rtl/rds_pkg.sv
package rds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP1  = 3'd1,
    ST_XFER  = 3'd2,
    ST_GAP2  = 3'd3,
    ST_RAMP  = 3'd4
  } rds_state_e;
endpackage

// File: rtl/rds_fsm.sv
module rds_fsm
  import rds_pkg::*;
#(
  parameter int XW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          ramp_end_i,
  input  logic [XW-1:0] xfer_len_i,
  output logic          sw1_o,
  output logic          sw2_o,
  output logic          sw3_o,
  output logic          busy_o,
  output logic          ramp_start_o,
  output logic          ramp_act_o
);
  rds_state_e    state_q;
  logic [XW-1:0] xc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      xc_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (hit_i) state_q <= ST_GAP1;
        ST_GAP1: begin
          state_q <= ST_XFER;
          xc_q    <= (xfer_len_i == '0) ? '0 : xfer_len_i - 1'b1;
        end
        ST_XFER: begin
          if (xc_q == '0) state_q <= ST_GAP2;
          else            xc_q    <= xc_q - 1'b1;
        end
        ST_GAP2: state_q <= ST_RAMP;
        ST_RAMP: if (ramp_end_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sw1_o        = (state_q == ST_IDLE) && hit_i;
  assign sw2_o        = (state_q == ST_XFER);
  assign sw3_o        = (state_q == ST_RAMP);
  assign busy_o       = (state_q != ST_IDLE);
  assign ramp_start_o = (state_q == ST_GAP2);
  assign ramp_act_o   = (state_q == ST_RAMP);

  // R5
  switch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw1_o, sw2_o, sw3_o}));

  // R3
  xfer_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw2_o) |-> (!$past(sw1_o) && !$past(sw3_o)));

  // R4
  ramp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw3_o) |-> !$past(sw2_o));

  // R2
  charge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw1_o && !busy_o) |=> (busy_o && !sw1_o));
endmodule

// File: rtl/rds_rundown.sv
module rds_rundown #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ramp_start_i,
  input  logic          ramp_act_i,
  input  logic          cmp_i,
  output logic          ramp_end_o,
  output logic          valid_o,
  output logic [CW-1:0] fine_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  assign ramp_end_o = ramp_act_i && (cmp_i || (cnt_q == CNT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      fine_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= ramp_end_o;
      if (ramp_start_i)
        cnt_q <= {{(CW-1){1'b0}}, 1'b1};
      else if (ramp_act_i && !ramp_end_o)
        cnt_q <= cnt_q + 1'b1;
      if (ramp_end_o) begin
        fine_o <= cnt_q;
        ovf_o  <= !cmp_i;
      end
    end
  end

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  valid_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_act_i && cmp_i) |=> (valid_o && !ovf_o));

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ovf_o) |-> (fine_o == CNT_MAX));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ramp_end_o) |-> ($stable(fine_o) && $stable(ovf_o)));
endmodule

// File: rtl/rds_deadcnt.sv
module rds_deadcnt #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          hit_i,
  output logic [DW-1:0] cnt_o
);
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cnt_o <= '0;
    else if (busy_i && hit_i && cnt_o != DMAX)   cnt_o <= cnt_o + 1'b1;
  end

  // R8
  dead_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && hit_i && cnt_o != DMAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R8
  dead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_i && hit_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rundown_seq.sv
module rundown_seq #(
  parameter int XW = 4,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          cmp_i,
  input  logic [XW-1:0] xfer_len_i,
  output logic          sw_charge_o,
  output logic          sw_xfer_o,
  output logic          sw_ramp_o,
  output logic          busy_o,
  output logic          valid_o,
  output logic [CW-1:0] fine_o,
  output logic          ovf_o,
  output logic [DW-1:0] dead_cnt_o
);
  logic ramp_end, ramp_start, ramp_act;

  rds_fsm #(.XW(XW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ramp_end_i(ramp_end),
    .xfer_len_i(xfer_len_i), .sw1_o(sw_charge_o), .sw2_o(sw_xfer_o),
    .sw3_o(sw_ramp_o), .busy_o(busy_o), .ramp_start_o(ramp_start),
    .ramp_act_o(ramp_act)
  );

  rds_rundown #(.CW(CW)) u_rundown (
    .clk(clk), .rst_n(rst_n), .ramp_start_i(ramp_start),
    .ramp_act_i(ramp_act), .cmp_i(cmp_i), .ramp_end_o(ramp_end),
    .valid_o(valid_o), .fine_o(fine_o), .ovf_o(ovf_o)
  );

  rds_deadcnt #(.DW(DW)) u_dead (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_o), .hit_i(hit_i),
    .cnt_o(dead_cnt_o)
  );

  // R9
  idle_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!busy_o && !sw_xfer_o && !sw_ramp_o));
endmodule

// File: tb/rundown_seq_bench.sv
`timescale 1ns/1ps
module rundown_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit = 1'b0;
  logic       cmp = 1'b0;
  logic [3:0] xlen = 4'd2;
  logic       s1, s2, s3, busy, valid, ovf;
  logic [7:0] fine;
  logic [15:0] dead;

  int n_chk = 0;
  int n_bad = 0;
  int dead_exp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rundown_seq u_rundown_seq (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .cmp_i(cmp), .xfer_len_i(xlen),
    .sw_charge_o(s1), .sw_xfer_o(s2), .sw_ramp_o(s3), .busy_o(busy),
    .valid_o(valid), .fine_o(fine), .ovf_o(ovf), .dead_cnt_o(dead)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 switches", {s1, s2, s3}, 0);
    chk("R1 busy/valid", {busy, valid}, 0);
    chk("R1 fine", fine, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 dead", dead, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at the negedge of the cycle after the hit was sampled (gap 1).
  // k == 0: comparator never answers.
  task automatic run_rest(int n, int k, bit hammer);
    int neff = (n == 0) ? 1 : n;
    int kk = (k == 0) ? 255 : k;
    hit = hammer;
    chk("R2 charge released", s1, 0);
    chk("R2 busy", busy, 1);
    chk("R3 gap before transfer", {s2, s3}, 0);
    for (int i = 0; i < neff; i++) begin
      @(negedge clk);
      chk("R3 transfer high", s2, 1);
    end
    @(negedge clk);
    chk("R4 gap after transfer", {s1, s2, s3}, 0);
    for (int j = 1; j <= kk; j++) begin
      @(negedge clk);
      chk("R4 rundown high", s3, 1);
      if (k != 0 && j == kk) cmp = 1'b1;
    end
    if (hammer) dead_exp += 2 + neff + kk;
    @(negedge clk);
    cmp = 1'b0;
    chk("R6 valid", valid, 1);
    chk("R6 rundown low", s3, 0);
    chk(k == 0 ? "R7 fine sat" : "R6 fine", fine, kk);
    chk("R7 ovf", ovf, k == 0 ? 1 : 0);
    chk("R9 idle", busy, 0);
    chk("R8 dead", dead, dead_exp);
  endtask

  task automatic t_convert(int n, int k);
    xlen = n[3:0];
    hit = 1'b1;
    #0;
    chk("R2 charge same cycle", s1, 1);
    chk("R2 not busy yet", busy, 0);
    @(negedge clk);
    hit = 1'b0;
    run_rest(n, k, 1'b0);
    hit = 1'b0;
    @(negedge clk);
    chk("R6 valid single", valid, 0);
    chk("R10 fine held", fine, (k == 0) ? 255 : k);
    chk("R10 ovf held", ovf, (k == 0) ? 1 : 0);
    @(negedge clk);
  endtask

  // Hit held through busy and into the valid cycle.
  task automatic t_hammer();
    xlen = 4'd3;
    hit = 1'b1;
    @(negedge clk);
    run_rest(3, 4, 1'b1);
    hit = 1'b1;
    #0;
    chk("R9 charge in valid cycle", s1, 1);
    @(negedge clk);
    hit = 1'b0;
    chk("R9 restarted busy", busy, 1);
    chk("R8 valid-cycle hit not dead", dead, dead_exp);
    chk("R10 fine held across restart", fine, 4);
    run_rest(3, 2, 1'b0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_convert(2, 5);
    t_convert(1, 1);
    t_convert(0, 3);
    t_convert(15, 40);
    t_convert(2, 0);
    t_convert(2, 7);
    t_hammer();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule